// File: doc/BRIEF.md
# I2C Master Repeated-Start Sequencer

This block produces an I2C repeated start on an open-drain SDA/SCL pair. When a byte transfer ends (signalled by a one-cycle pulse on `ninth_fall` at the falling edge of the ninth clock), the sequencer parks with both lines pulled low. Software then sets the repeated-start request bit in the control register. The block then walks through three timed phases, each one baud-generator period long. First SDA is released while SCL stays low. Next SCL is released. Last SDA is pulled low while SCL stays high. On completion the request bit clears by itself, and the start-seen and interrupt flags are raised.

While the sequence runs the register port is partly locked. A write to the transmit buffer is dropped and flagged as a write collision. Writes to the low five control bits have no effect. Once the sequence is complete, a transmit-buffer write is accepted. It is offered downstream on a valid/ready pair that starts the first data bit. `tx_valid` stays high with `tx_data` stable until `tx_ready` is seen high. On that handshake the sequencer hands the bus back and releases both lines. A buffer write while `tx_valid` is still pending is also a collision and is discarded.

Top module: `i2c_rstart_seq`

## Requirements
- R1: After synchronous reset `rst`, both drive enables, `busy`, `tx_valid`, all flags and the control register are 0.
- R2: A control write with bit 0 = 1 does not start the sequence until a `ninth_fall` pulse has been seen. After that pulse, and before the sequence starts, both `sda_oe` and `scl_oe` are 1.
- R3: Phase 1 (`sda_oe`=0, `scl_oe`=1) lasts `brg_reload`+1 cycles.
- R4: Phase 2 (`sda_oe`=0, `scl_oe`=0) lasts `brg_reload`+1 cycles, plus one cycle for every cycle that `scl_in` is sampled low while SCL is released.
- R5: Phase 3 (`sda_oe`=1, `scl_oe`=0) lasts `brg_reload`+1 cycles. SDA is never pulled low while SCL is driven low during the sequence.
- R6: On completion, in the same cycle, control bit 0 clears and `start_flag` and `irq_flag` set. SDA stays low and SCL stays released until a handoff.
- R7: A transmit-buffer write (`wr_addr`=1) while `busy` sets `wcol_flag` and leaves `tx_data` and `tx_valid` unchanged.
- R8: A control write (`wr_addr`=0) while `busy` leaves control bits [4:0] unchanged and writes bits [7:5].
- R9: A status write (`wr_addr`=2) clears each flag whose data bit is 0 (bit 0 start, bit 1 interrupt, bit 2 collision) and leaves a flag whose bit is 1.
- R10: After completion a buffer write raises `tx_valid` with the data. `tx_valid` holds with stable data until `tx_ready`. A write while pending sets `wcol_flag` and is dropped. The handshake releases both lines.
- R11: `busy` is 1 exactly during the three timed phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 transmit buffer, 2 status clear |
| wr_data | input | 8 | Write data |
| brg_reload | input | RW | Baud generator reload count |
| ninth_fall | input | 1 | Pulse: previous byte transfer has ended |
| scl_in | input | 1 | Sampled SCL line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| scl_oe | output | 1 | Pull SCL low when 1 |
| busy | output | 1 | Timed phases in progress |
| ctrl_q | output | 8 | Control register contents |
| start_flag | output | 1 | Start condition completed |
| irq_flag | output | 1 | Interrupt flag |
| wcol_flag | output | 1 | Write collision flag |
| tx_valid | output | 1 | Transmit byte offered downstream |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_data | output | 8 | Transmit buffer contents |

## Verification
On every cycle, the assertions check the write lockout (collision on buffer writes, frozen low control bits), the line-ordering rule that SDA never falls while SCL is held low, and the freezing of the drive pattern while SCL is stretched. They also check the simultaneous clear and flag set at completion, the valid/ready hold rule and the reset state. Phase lengths for different reload counts, the exact stretch extension, the wait for the end of the byte, and the full handoff are shown only by the bench's scenarios.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PARK,
    ST_SDA_REL,
    ST_SCL_REL,
    ST_SDA_LOW,
    ST_HELD
  } rs_state_t;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_TXBUF  = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;

  localparam int FLAG_START = 0;
  localparam int FLAG_IRQ   = 1;
  localparam int FLAG_WCOL  = 2;
  localparam int NUM_FLAGS  = 3;
endpackage

// File: rtl/rs_brg.sv
module rs_brg #(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          hold,
  input  logic [RW-1:0] reload,
  output logic          tick
);
  logic [RW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= reload;
    end else if (!hold) begin
      cnt_q <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
    end
  end

  assign tick = run && !hold && (cnt_q == '0);
endmodule

// File: rtl/rs_regs.sv
module rs_regs
  import i2c_rs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          busy,
  input  logic          done,
  input  logic          tx_ready,
  output logic [DW-1:0] ctrl_q,
  output logic [NUM_FLAGS-1:0] flags_q,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data
);
  localparam int LOCKED_BITS = 5;

  logic wr_ctrl, wr_tx, wr_stat, tx_collide;
  logic [NUM_FLAGS-1:0] flag_set;

  assign wr_ctrl    = wr_en && (wr_addr == ADDR_CTRL);
  assign wr_tx      = wr_en && (wr_addr == ADDR_TXBUF);
  assign wr_stat    = wr_en && (wr_addr == ADDR_STATUS);
  assign tx_collide = wr_tx && (busy || tx_valid);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q[DW-1:LOCKED_BITS] <= wr_data[DW-1:LOCKED_BITS];
        if (!busy) ctrl_q[LOCKED_BITS-1:0] <= wr_data[LOCKED_BITS-1:0];
      end
      if (done) ctrl_q[0] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (wr_tx && !tx_collide) begin
      tx_valid <= 1'b1;
      tx_data  <= wr_data;
    end else if (tx_valid && tx_ready) begin
      tx_valid <= 1'b0;
    end
  end

  always_comb begin
    flag_set             = '0;
    flag_set[FLAG_START] = done;
    flag_set[FLAG_IRQ]   = done;
    flag_set[FLAG_WCOL]  = tx_collide;
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)               flags_q[g] <= 1'b0;
      else if (flag_set[g])  flags_q[g] <= 1'b1;
      else if (wr_stat && !wr_data[g]) flags_q[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/rs_fsm.sv
module rs_fsm
  import i2c_rs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ninth_fall,
  input  logic rs_req,
  input  logic tick,
  input  logic handoff,
  input  logic scl_in,
  output logic sda_oe,
  output logic scl_oe,
  output logic busy,
  output logic hold,
  output logic done
);
  rs_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (ninth_fall) st_d = ST_PARK;
      ST_PARK:    if (handoff) st_d = ST_IDLE;
                  else if (rs_req) st_d = ST_SDA_REL;
      ST_SDA_REL: if (tick) st_d = ST_SCL_REL;
      ST_SCL_REL: if (tick) st_d = ST_SDA_LOW;
      ST_SDA_LOW: if (tick) st_d = ST_HELD;
      ST_HELD:    if (handoff) st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  always_comb begin
    sda_oe = 1'b0;
    scl_oe = 1'b0;
    unique case (st_q)
      ST_PARK:    begin sda_oe = 1'b1; scl_oe = 1'b1; end
      ST_SDA_REL: scl_oe = 1'b1;
      ST_SDA_LOW: sda_oe = 1'b1;
      ST_HELD:    sda_oe = 1'b1;
      default:    ;
    endcase
  end

  assign busy = (st_q == ST_SDA_REL) || (st_q == ST_SCL_REL) || (st_q == ST_SDA_LOW);
  assign hold = ((st_q == ST_SCL_REL) || (st_q == ST_SDA_LOW)) && !scl_in;
  assign done = (st_q == ST_SDA_LOW) && tick;
endmodule

// File: rtl/i2c_rstart_seq.sv
module i2c_rstart_seq
  import i2c_rs_pkg::*;
#(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [RW-1:0] brg_reload,
  input  logic          ninth_fall,
  input  logic          scl_in,
  output logic          sda_oe,
  output logic          scl_oe,
  output logic          busy,
  output logic [7:0]    ctrl_q,
  output logic          start_flag,
  output logic          irq_flag,
  output logic          wcol_flag,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data
);
  logic tick, hold, done;
  logic [NUM_FLAGS-1:0] flags;

  rs_fsm u_fsm (
    .clk(clk), .rst(rst), .ninth_fall(ninth_fall), .rs_req(ctrl_q[0]),
    .tick(tick), .handoff(tx_valid && tx_ready), .scl_in(scl_in),
    .sda_oe(sda_oe), .scl_oe(scl_oe), .busy(busy), .hold(hold), .done(done)
  );

  rs_brg #(.RW(RW)) u_brg (
    .clk(clk), .rst(rst), .run(busy), .hold(hold), .reload(brg_reload), .tick(tick)
  );

  rs_regs #(.DW(8)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .tx_ready(tx_ready), .ctrl_q(ctrl_q),
    .flags_q(flags), .tx_valid(tx_valid), .tx_data(tx_data)
  );

  assign start_flag = flags[FLAG_START];
  assign irq_flag   = flags[FLAG_IRQ];
  assign wcol_flag  = flags[FLAG_WCOL];
endmodule

// File: rtl/i2c_rstart_seq_chk.sv
module i2c_rstart_seq_chk #(
  parameter int RW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [1:0]    wr_addr,
  input logic [7:0]    wr_data,
  input logic [RW-1:0] brg_reload,
  input logic          ninth_fall,
  input logic          scl_in,
  input logic          sda_oe,
  input logic          scl_oe,
  input logic          busy,
  input logic [7:0]    ctrl_q,
  input logic          start_flag,
  input logic          irq_flag,
  input logic          wcol_flag,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!sda_oe && !scl_oe && !busy && !tx_valid && !start_flag && !wcol_flag));

  assert_stretch_freeze_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && !scl_oe && !scl_in) |=> ($stable(sda_oe) && $stable(scl_oe) && busy));

  assert_sda_low_needs_scl_high_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && sda_oe) |-> !scl_oe);

  assert_completion_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(start_flag) |-> (!ctrl_q[0] && irq_flag && sda_oe && !scl_oe));

  assert_tx_collision_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en && wr_addr == 2'd1) |=> (wcol_flag && $stable(tx_data) && $stable(tx_valid)));

  assert_ctrl_lock_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en && wr_addr == 2'd0) |=> $stable(ctrl_q[4:1]));

  assert_tx_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
endmodule

bind i2c_rstart_seq i2c_rstart_seq_chk #(.RW(RW)) u_chk (.*);

// File: tb/i2c_rstart_seq_bench.sv
module i2c_rstart_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 8;
  localparam int NVEC = 4;
  // each entry: {reload, stretch cycles}
  localparam logic [15:0] VEC [NVEC] = '{16'h0000, 16'h0300, 16'h0502, 16'h0204};

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, ninth_fall = 1'b0, tx_ready = 1'b0;
  logic force_low = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [RW-1:0] brg_reload = '0;
  logic scl_in, sda_oe, scl_oe, busy, start_flag, irq_flag, wcol_flag, tx_valid;
  logic [7:0] ctrl_q, tx_data;
  int checks = 0, errors = 0;
  bit finished = 0;

  assign scl_in = ~(scl_oe | force_low);

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_rstart_seq #(.RW(RW)) u_i2c_rstart_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .brg_reload(brg_reload), .ninth_fall(ninth_fall), .scl_in(scl_in),
    .sda_oe(sda_oe), .scl_oe(scl_oe), .busy(busy), .ctrl_q(ctrl_q),
    .start_flag(start_flag), .irq_flag(irq_flag), .wcol_flag(wcol_flag),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; force_low = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_ninth();
    @(negedge clk); ninth_fall = 1'b1;
    @(negedge clk); ninth_fall = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // table walk: R3 R4 R5 R6 R11
    for (int i = 0; i < NVEC; i++) begin
      int rl, sl, left, n1, n2, n3, guard;
      rl = VEC[i][15:8]; sl = VEC[i][7:0];
      brg_reload = RW'(rl);
      do_reset();
      pulse_ninth();
      wr(2'd0, 8'h01);
      n1 = 0; n2 = 0; n3 = 0; left = sl; guard = 0;
      while (!start_flag && guard < 500) begin
        @(negedge clk);
        guard++;
        if (busy && scl_oe && !sda_oe) n1++;
        else if (busy && !scl_oe && !sda_oe) n2++;
        else if (busy && !scl_oe && sda_oe) n3++;
        if (busy && !scl_oe && !sda_oe && left > 0) begin
          force_low = 1'b1; left--;
        end else force_low = 1'b0;
      end
      chk("R3 phase1 length", n1, rl + 1);
      chk("R4 phase2 length", n2, rl + 1 + sl);
      chk("R5 phase3 length", n3, rl + 1);
      chk("R6 enable cleared", int'(ctrl_q[0]), 0);
      chk("R6 irq set", int'(irq_flag), 1);
      chk("R6 lines held", int'({sda_oe, scl_oe}), 2);
      chk("R11 busy low after", int'(busy), 0);
    end

    // R1 reset state
    brg_reload = 8'd10;
    do_reset();
    chk("R1 lines", int'({sda_oe, scl_oe, busy}), 0);
    chk("R1 flags", int'({start_flag, irq_flag, wcol_flag, tx_valid}), 0);
    chk("R1 ctrl", int'(ctrl_q), 0);

    // R2 waits for the end of the byte
    wr(2'd0, 8'h01);
    repeat (8) @(negedge clk);
    chk("R2 no start before ninth", int'({busy, sda_oe, scl_oe}), 0);
    pulse_ninth();
    chk("R2 parked", int'({busy, sda_oe, scl_oe}), 3);
    @(negedge clk);
    chk("R11 busy in phase1", int'({busy, sda_oe, scl_oe}), 5);

    // R7 / R8 lockout while busy
    wr(2'd1, 8'hAA);
    chk("R7 wcol set", int'(wcol_flag), 1);
    chk("R7 buffer unchanged", int'({tx_valid, tx_data}), 0);
    wr(2'd0, 8'hFE);
    chk("R8 ctrl lock", int'(ctrl_q), 8'hE1);

    for (int g = 0; g < 200 && !start_flag; g++) @(negedge clk);
    chk("R6 start flag", int'(start_flag), 1);
    chk("R6 ctrl after", int'(ctrl_q), 8'hE0);

    // R9 write-zero clear
    wr(2'd2, 8'hFB);
    chk("R9 wcol cleared", int'(wcol_flag), 0);
    chk("R9 others kept", int'({start_flag, irq_flag}), 3);

    // R10 handoff
    wr(2'd1, 8'h5A);
    chk("R10 valid", int'(tx_valid), 1);
    chk("R10 data", int'(tx_data), 8'h5A);
    repeat (3) @(negedge clk);
    chk("R10 valid held", int'({tx_valid, tx_data}), 9'h15A);
    wr(2'd1, 8'h33);
    chk("R10 pending collision", int'(wcol_flag), 1);
    chk("R10 data kept", int'(tx_data), 8'h5A);
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    chk("R10 valid dropped", int'(tx_valid), 0);
    chk("R10 lines released", int'({sda_oe, scl_oe}), 0);
    wr(2'd2, 8'hFE);
    chk("R9 start cleared only", int'({start_flag, irq_flag}), 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule